// File: doc/BRIEF.md
# Game Cartridge PRG Bank Mapper

This block performs the address translation of a simple discrete-logic cartridge mapper. It watches a CPU bus and a picture-processor bus. For each access it produces the physical address and the chip selects for the program ROM, the pattern memory (read-only or writable) and the console's 2 KB nametable RAM. The memory arrays themselves sit outside the block.

The 32 KB CPU program space at $8000–$FFFF splits into two 16 KB windows. The window at $C000–$FFFF is wired permanently to the highest bank of program ROM. The window at $8000–$BFFF follows a bank register, and any CPU write into $8000–$FFFF loads that register. On the picture side, $0000–$1FFF reaches an unswitched 8 KB pattern region. The range $2000–$3EFF folds onto the nametable RAM using a mirroring mode strapped by the cartridge. Every output is registered, so a translation appears one clock after the bus cycle that caused it.

Top module: `prg_bank_mapper`

## Requirements
- R1: While `rst` is high and in the cycle after it, every select and write-enable output is 0 and every address output is 0. The bank register comes out of reset holding 0.
- R2: A CPU read (`cpu_wr`=0) of $8000–$BFFF gives `prg_sel`=1 and `prg_addr` = {bank register, cpu_addr[13:0]} one clock later.
- R3: A CPU read of $C000–$FFFF gives `prg_sel`=1 and `prg_addr` = {all ones, cpu_addr[13:0]} one clock later, whatever the bank register holds.
- R4: A CPU write to any address in $8000–$FFFF loads `cpu_wdata` modulo PRG_BANKS (its low log2(PRG_BANKS) bits) into the bank register. Reads from the next cycle on use the new value.
- R5: A CPU write below $8000 leaves the bank register unchanged. Any CPU access below $8000 gives `prg_sel`=0 and `prg_addr`=0.
- R6: A CPU write never asserts `prg_sel`.
- R7: A picture-bus read of $0000–$1FFF gives `chr_sel`=1, `chr_we`=0 and `chr_addr` = ppu_addr[12:0] one clock later, with `nt_sel`=0.
- R8: A picture-bus write to $0000–$1FFF gives `chr_sel`=1 and `chr_we`=1 when CHR_RAM=1. When CHR_RAM=0 it gives `chr_sel`=0 and `chr_we`=0, so the write is ignored.
- R9: A picture-bus access to $2000–$3EFF gives `nt_sel`=1, with `nt_we` equal to `ppu_wr`. `nt_addr` = {ppu_addr[10], ppu_addr[9:0]} when `mirror_horiz`=0 (vertical). It is {ppu_addr[11], ppu_addr[9:0]} when `mirror_horiz`=1 (horizontal).
- R10: A picture-bus access to $3F00–$3FFF selects nothing: `chr_sel`, `chr_we`, `nt_sel` and `nt_we` are 0 and both picture addresses are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | 1 = CPU write, 0 = CPU read |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_wr | input | 1 | 1 = picture-bus write |
| mirror_horiz | input | 1 | Mirroring strap: 0 vertical, 1 horizontal |
| prg_addr | output | log2(PRG_BANKS)+14 | Program ROM byte address |
| prg_sel | output | 1 | Program ROM select |
| chr_addr | output | 13 | Pattern memory address |
| chr_sel | output | 1 | Pattern memory select |
| chr_we | output | 1 | Pattern RAM write enable |
| nt_addr | output | 11 | Nametable RAM address |
| nt_sel | output | 1 | Nametable RAM select |
| nt_we | output | 1 | Nametable RAM write enable |

## Verification
The bank register gets byte values both inside and outside the bank range, written at the bottom, the middle and the top of upper CPU space. This separates true modulo decoding from a decode of only the first address. Reads at the very edges of each window ($8000, $BFFF, $C000, $FFFF) under several bank values show whether bit 14 alone picks the fixed window. Nametable addresses where bits 10 and 11 differ tell the two mirroring modes apart, and $3EFF against $3F00 pins down the end of the nametable range. Two instances, one with pattern RAM and one with pattern ROM, take the same pattern writes.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic {
    MIRR_VERT  = 1'b0,
    MIRR_HORIZ = 1'b1
  } mirror_e;

  typedef enum logic [1:0] {
    PPU_PATTERN = 2'd0,
    PPU_NAMETBL = 2'd1,
    PPU_NONE    = 2'd2
  } ppu_region_e;

  // Picture-bus region decode over a 14-bit address.
  function automatic ppu_region_e ppu_region(input logic [13:0] a);
    if (!a[13])                   return PPU_PATTERN;
    else if (a[12:8] != 5'h1F)    return PPU_NAMETBL;
    else                          return PPU_NONE;
  endfunction

endpackage

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
  parameter int BANK_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk) begin
    if (rst)        bank <= '0;
    else if (wr_en) bank <= wr_data[BANK_W-1:0];
  end

  generate
    if (DATA_W > BANK_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:BANK_W];
    end
  endgenerate

  // R4: a load takes the low bits of the written byte
  a_r4_bank_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> bank == $past(wr_data[BANK_W-1:0]));

  // R5: without a load the register holds
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank));

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate #(
  parameter int BANK_W = 3,
  parameter int WIN_W  = 14,
  localparam int PRG_AW = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [BANK_W-1:0] bank,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_sel
);

  logic              hit;
  logic [BANK_W-1:0] win_bank;
  logic [PRG_AW-1:0] addr_nxt;

  always_comb begin
    hit      = cpu_addr[15] & ~cpu_wr;
    win_bank = cpu_addr[14] ? {BANK_W{1'b1}} : bank;
    addr_nxt = hit ? {win_bank, cpu_addr[WIN_W-1:0]} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      prg_sel  <= 1'b0;
    end else begin
      prg_addr <= addr_nxt;
      prg_sel  <= hit;
    end
  end

  // R3: upper window always lands on the last bank
  a_r3_fixed_upper: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15] && cpu_addr[14] && !cpu_wr) |=> (prg_sel && prg_addr[PRG_AW-1:WIN_W] == {BANK_W{1'b1}}));

  // R5: nothing below $8000 selects program ROM
  a_r5_low_unselected: assert property (@(posedge clk) disable iff (rst)
    !cpu_addr[15] |=> (!prg_sel && prg_addr == '0));

  // R6: writes never select program ROM
  a_r6_write_nosel: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> !prg_sel);

endmodule

// File: rtl/mapper_ppu_xlate.sv
module mapper_ppu_xlate
  import mapper_pkg::*;
#(
  parameter bit CHR_RAM = 1'b1,
  parameter int CHR_AW  = 13,
  parameter int NT_AW   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_wr,
  input  mirror_e           mirror,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_sel,
  output logic              chr_we,
  output logic [NT_AW-1:0]  nt_addr,
  output logic              nt_sel,
  output logic              nt_we
);

  ppu_region_e       region;
  logic              pat_hit, nt_hit;
  logic              chr_sel_nxt, chr_we_nxt;
  logic              nt_bank_bit;
  logic [CHR_AW-1:0] chr_addr_nxt;
  logic [NT_AW-1:0]  nt_addr_nxt;

  always_comb begin
    region  = ppu_region(ppu_addr);
    pat_hit = (region == PPU_PATTERN);
    nt_hit  = (region == PPU_NAMETBL);
  end

  // Pattern memory: writable variant or read-only variant
  generate
    if (CHR_RAM) begin : g_chr_ram
      always_comb begin
        chr_sel_nxt = pat_hit;
        chr_we_nxt  = pat_hit & ppu_wr;
      end
    end else begin : g_chr_rom
      always_comb begin
        chr_sel_nxt = pat_hit & ~ppu_wr;
        chr_we_nxt  = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    chr_addr_nxt = chr_sel_nxt ? ppu_addr[CHR_AW-1:0] : '0;
    nt_bank_bit  = (mirror == MIRR_HORIZ) ? ppu_addr[11] : ppu_addr[10];
    nt_addr_nxt  = nt_hit ? {nt_bank_bit, ppu_addr[NT_AW-2:0]} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      chr_sel  <= 1'b0;
      chr_we   <= 1'b0;
      nt_addr  <= '0;
      nt_sel   <= 1'b0;
      nt_we    <= 1'b0;
    end else begin
      chr_addr <= chr_addr_nxt;
      chr_sel  <= chr_sel_nxt;
      chr_we   <= chr_we_nxt;
      nt_addr  <= nt_addr_nxt;
      nt_sel   <= nt_hit;
      nt_we    <= nt_hit & ppu_wr;
    end
  end

  // R9: pattern and nametable selects are exclusive
  a_r9_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chr_sel, nt_sel}));

  // R8: a write enable implies its select
  a_r8_we_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (chr_we |-> chr_sel) and (nt_we |-> nt_sel));

  // R10: $3F00-$3FFF reaches no memory
  a_r10_top_unselected: assert property (@(posedge clk) disable iff (rst)
    (ppu_addr[13:8] == 6'h3F) |=> (!chr_sel && !nt_sel && !chr_we && !nt_we));

  // R9: nametable low bits pass through
  a_r9_nt_low_bits: assert property (@(posedge clk) disable iff (rst)
    (ppu_addr[13] && ppu_addr[12:8] != 5'h1F) |=> (nt_sel && nt_addr[NT_AW-2:0] == $past(ppu_addr[NT_AW-2:0])));

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import mapper_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter bit CHR_RAM   = 1'b1,
  localparam int BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int WIN_W    = 14,
  localparam int PRG_AW   = BANK_W + WIN_W,
  localparam int CHR_AW   = 13,
  localparam int NT_AW    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_wr,
  input  logic              mirror_horiz,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_sel,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_sel,
  output logic              chr_we,
  output logic [NT_AW-1:0]  nt_addr,
  output logic              nt_sel,
  output logic              nt_we
);

  logic [BANK_W-1:0] bank;
  logic              bank_load;
  mirror_e           mirror;

  assign bank_load = cpu_wr & cpu_addr[15];
  assign mirror    = mirror_e'(mirror_horiz);

  mapper_bank_reg #(
    .BANK_W (BANK_W),
    .DATA_W (8)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_load),
    .wr_data (cpu_wdata),
    .bank    (bank)
  );

  mapper_prg_xlate #(
    .BANK_W (BANK_W),
    .WIN_W  (WIN_W)
  ) u_prg (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .bank     (bank),
    .prg_addr (prg_addr),
    .prg_sel  (prg_sel)
  );

  mapper_ppu_xlate #(
    .CHR_RAM (CHR_RAM),
    .CHR_AW  (CHR_AW),
    .NT_AW   (NT_AW)
  ) u_ppu (
    .clk      (clk),
    .rst      (rst),
    .ppu_addr (ppu_addr),
    .ppu_wr   (ppu_wr),
    .mirror   (mirror),
    .chr_addr (chr_addr),
    .chr_sel  (chr_sel),
    .chr_we   (chr_we),
    .nt_addr  (nt_addr),
    .nt_sel   (nt_sel),
    .nt_we    (nt_we)
  );

  // R1: reset clears every output on the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!prg_sel && !chr_sel && !chr_we && !nt_sel && !nt_we && prg_addr == '0));

  // R2: lower window follows the bank register
  a_r2_lower_window: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b10 && !cpu_wr) |=> (prg_sel && prg_addr[PRG_AW-1:WIN_W] == $past(bank)));

endmodule

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

  localparam int PRG_AW = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = 14'h3FFF;
  logic        ppu_wr = 1'b0;
  logic        mirror_horiz = 1'b0;

  logic [PRG_AW-1:0] prg_addr, prg_addr_r;
  logic              prg_sel, prg_sel_r;
  logic [12:0]       chr_addr, chr_addr_r;
  logic              chr_sel, chr_sel_r, chr_we, chr_we_r;
  logic [10:0]       nt_addr, nt_addr_r;
  logic              nt_sel, nt_sel_r, nt_we, nt_we_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prg_bank_mapper #(.PRG_BANKS(8), .CHR_RAM(1'b1)) u_prg_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .mirror_horiz(mirror_horiz),
    .prg_addr(prg_addr), .prg_sel(prg_sel), .chr_addr(chr_addr), .chr_sel(chr_sel),
    .chr_we(chr_we), .nt_addr(nt_addr), .nt_sel(nt_sel), .nt_we(nt_we));

  prg_bank_mapper #(.PRG_BANKS(8), .CHR_RAM(1'b0)) u_prg_bank_mapper_rom (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .mirror_horiz(mirror_horiz),
    .prg_addr(prg_addr_r), .prg_sel(prg_sel_r), .chr_addr(chr_addr_r), .chr_sel(chr_sel_r),
    .chr_we(chr_we_r), .nt_addr(nt_addr_r), .nt_sel(nt_sel_r), .nt_we(nt_we_r));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One bus cycle: drive at the falling edge, sample just after the next rising edge
  task automatic cpu_cycle(input logic [15:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w;
    @(posedge clk); #1;
  endtask

  task automatic ppu_cycle(input logic [13:0] a, input logic w);
    @(negedge clk);
    ppu_addr = a; ppu_wr = w;
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] lo_win(input logic [2:0] b, input logic [15:0] a);
    return 32'({b, a[13:0]});
  endfunction

  task automatic t_reset();
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_wr = 1'b0; ppu_addr = 14'h0100;
    @(posedge clk); #1;
    chk("R1", "prg_sel in reset", 32'(prg_sel), 0);
    chk("R1", "chr_sel in reset", 32'(chr_sel), 0);
    chk("R1", "nt_sel/we in reset", 32'({nt_sel, nt_we, chr_we}), 0);
    chk("R1", "prg_addr in reset", 32'(prg_addr), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "bank after reset", 32'(prg_addr), lo_win(3'd0, 16'h8000));
    ppu_cycle(14'h3FFF, 1'b0);
  endtask

  task automatic t_switch_lower();
    cpu_cycle(16'h8000, 8'h05, 1'b1);
    chk("R6", "prg_sel on write", 32'(prg_sel), 0);
    cpu_cycle(16'h8123, 8'h00, 1'b0);
    chk("R2", "lower window sel", 32'(prg_sel), 1);
    chk("R2", "lower window addr", 32'(prg_addr), lo_win(3'd5, 16'h8123));
    cpu_cycle(16'hBFFF, 8'h00, 1'b0);
    chk("R2", "lower window top", 32'(prg_addr), lo_win(3'd5, 16'hBFFF));
  endtask

  task automatic t_write_anywhere();
    cpu_cycle(16'hFFF0, 8'h0D, 1'b1);
    chk("R6", "prg_sel on high write", 32'(prg_sel), 0);
    cpu_cycle(16'h8000, 8'h00, 1'b0);
    chk("R4", "modulo bank 0x0D", 32'(prg_addr), lo_win(3'd5, 16'h8000));
    cpu_cycle(16'hC000, 8'hFA, 1'b1);
    cpu_cycle(16'hA5A5, 8'h00, 1'b0);
    chk("R4", "bank via $C000 write", 32'(prg_addr), lo_win(3'd2, 16'hA5A5));
    cpu_cycle(16'hA000, 8'h03, 1'b1);
    cpu_cycle(16'hA000, 8'h00, 1'b0);
    chk("R4", "bank via $A000 write", 32'(prg_addr), lo_win(3'd3, 16'hA000));
  endtask

  task automatic t_fixed_upper();
    for (int i = 0; i < 2; i++) begin
      logic [7:0] bsel = (i == 0) ? 8'h00 : 8'h03;
      cpu_cycle(16'h9000, bsel, 1'b1);
      cpu_cycle(16'hC456, 8'h00, 1'b0);
      chk("R3", "upper window sel", 32'(prg_sel), 1);
      chk("R3", "upper window $C456", 32'(prg_addr), lo_win(3'd7, 16'hC456));
      cpu_cycle(16'hFFFF, 8'h00, 1'b0);
      chk("R3", "upper window $FFFF", 32'(prg_addr), lo_win(3'd7, 16'hFFFF));
    end
  endtask

  task automatic t_low_space();
    cpu_cycle(16'h8000, 8'h06, 1'b1);
    cpu_cycle(16'h7FFF, 8'h01, 1'b1);
    cpu_cycle(16'h6000, 8'h02, 1'b1);
    cpu_cycle(16'h4020, 8'h00, 1'b0);
    chk("R5", "sel below $8000", 32'(prg_sel), 0);
    chk("R5", "addr below $8000", 32'(prg_addr), 0);
    cpu_cycle(16'h8001, 8'h00, 1'b0);
    chk("R5", "bank kept after low writes", 32'(prg_addr), lo_win(3'd6, 16'h8001));
  endtask

  task automatic t_pattern();
    ppu_cycle(14'h1ABC, 1'b0);
    chk("R7", "chr_sel read", 32'({chr_sel, chr_we, nt_sel}), 32'b100);
    chk("R7", "chr_addr read", 32'(chr_addr), 32'h1ABC);
    chk("R7", "rom chr read", 32'({chr_sel_r, chr_addr_r}), 32'({1'b1, 13'h1ABC}));
  endtask

  task automatic t_chr_write();
    ppu_cycle(14'h0123, 1'b1);
    chk("R8", "ram chr sel/we", 32'({chr_sel, chr_we}), 32'b11);
    chk("R8", "ram chr addr", 32'(chr_addr), 32'h0123);
    chk("R8", "rom chr write ignored", 32'({chr_sel_r, chr_we_r, nt_sel_r}), 0);
    ppu_cycle(14'h3FFF, 1'b0);
  endtask

  task automatic t_nametable();
    mirror_horiz = 1'b0;
    ppu_cycle(14'h2805, 1'b0);
    chk("R9", "vert $2805", 32'({nt_sel, nt_we, nt_addr}), 32'({2'b10, 11'h005}));
    ppu_cycle(14'h2405, 1'b1);
    chk("R9", "vert $2405 write", 32'({nt_sel, nt_we, nt_addr}), 32'({2'b11, 11'h405}));
    chk("R9", "no chr on nt", 32'({chr_sel, chr_we}), 0);
    ppu_cycle(14'h3EFF, 1'b0);
    chk("R9", "vert $3EFF", 32'({nt_sel, nt_addr}), 32'({1'b1, 11'h6FF}));
    mirror_horiz = 1'b1;
    ppu_cycle(14'h2805, 1'b0);
    chk("R9", "horiz $2805", 32'({nt_sel, nt_addr}), 32'({1'b1, 11'h405}));
    ppu_cycle(14'h2405, 1'b0);
    chk("R9", "horiz $2405", 32'({nt_sel, nt_addr}), 32'({1'b1, 11'h005}));
    mirror_horiz = 1'b0;
  endtask

  task automatic t_top_region();
    ppu_cycle(14'h3F00, 1'b1);
    chk("R10", "$3F00 selects", 32'({chr_sel, chr_we, nt_sel, nt_we}), 0);
    chk("R10", "$3F00 addrs", 32'({chr_addr, nt_addr}), 0);
    ppu_cycle(14'h3FFF, 1'b0);
    chk("R10", "$3FFF selects", 32'({chr_sel, nt_sel}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_switch_lower();
    t_write_anywhere();
    t_fixed_upper();
    t_low_space();
    t_pattern();
    t_chr_write();
    t_nametable();
    t_top_region();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule